// File: doc/BRIEF.md
# Break-Even Idle State Selector

This block picks a low-power state for a single processing element when that element is about to go idle. A scheduler hands it a predicted idle duration and the absolute time at which the idle window ends. Software programs a small table beforehand. For each low-power state the table holds a transition latency and a break-even time, the shortest stay that pays back the cost of entering the state. Power and transition energy figures are folded into the break-even time before the table is written. The block selects the deepest state whose break-even time and whose round-trip transition (sleep plus wake) both fit inside the predicted window. It then raises a sleep request for that state.

When it enters a state, the block stores a wake-up instant. That instant is the idle end time minus the chosen state's latency. It compares this instant with a free-running time counter supplied from outside. When the counter reaches the instant, the block issues a one-cycle wake request, so the element is running again when the next task arrives. An external early-wake event cancels the pending timer and produces the wake request at once. State 0 means "stay active". Higher indices are deeper states.

Top module: `lp_state_picker`

## Requirements
- R1: After reset `state_idx` is 0 and `sleep_req` and `wake_req` are low.
- R2: A table write happens when `cfg_we` is high at a clock edge. `cfg_sel` (1..NUM_ST-1) names the state. `cfg_fld` 0 writes the transition latency and `cfg_fld` 1 writes the break-even time, both in clock cycles. A write with `cfg_sel` 0 has no effect on any later choice.
- R3: State k (k ≥ 1) is eligible for a predicted duration D only if D ≠ 0, break-even(k) ≤ D and 2·latency(k) ≤ D. The comparison is unsigned and free of overflow.
- R4: When `idle_vld` is high at an edge while `sleep_req` is low, the highest eligible index is chosen. From the next cycle `state_idx` shows it and `sleep_req` is high whenever it is non-zero.
- R5: When no state is eligible, or when D is 0, `state_idx` stays 0 and neither `sleep_req` nor `wake_req` is raised.
- R6: On entry the wake point is W = idle_end − latency(chosen), computed modulo 2^32. The timer fires at the first edge at which `now` − W, read as a signed 32-bit value, is ≥ 0. In the following cycle `wake_req` is high for exactly one cycle, `sleep_req` is low and `state_idx` is 0.
- R7: `early_wake` high at an edge while `sleep_req` is high cancels the timer. The next cycle shows the same one-cycle `wake_req` with `sleep_req` low and `state_idx` 0.
- R8: `idle_vld` arriving while `sleep_req` is high is ignored: `state_idx` is unchanged until the wake.
- R9: `early_wake` while `sleep_req` is low has no effect: no `wake_req` is produced.
- R10: If W is already reached at the first edge after entry, the wake request appears in the second cycle after the `idle_vld` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_sel | input | 2 | State index being written |
| cfg_fld | input | 1 | 0 = latency, 1 = break-even time |
| cfg_wdata | input | 32 | Value written, in cycles |
| idle_vld | input | 1 | Qualifies an idle prediction |
| idle_dur | input | 32 | Predicted idle duration, cycles |
| idle_end | input | 32 | Absolute time the idle window ends |
| now | input | 32 | Free-running time counter |
| early_wake | input | 1 | External event that forces a wake |
| state_idx | output | 2 | Current low-power state, 0 = active |
| sleep_req | output | 1 | Request to hold the element in `state_idx` |
| wake_req | output | 1 | One-cycle wake-up request |

## Verification
The hardest case to reach is a state that is barred only by its transition latency. Its break-even time is met, but twice its latency exceeds the window. A deeper state may also be eligible while a shallower one is not. The bench reaches these cases with a second table whose middle state has a short break-even time and a long latency. It then sweeps every duration from 0 to 70 across both tables, with the expected index computed arithmetically. For each vector it alternates between early-wake exits and timer exits, so that each timer exit shows the exact firing cycle.

// File: rtl/lp_pkg.sv
package lp_pkg;
  localparam int TIME_W = 32;
  typedef logic [TIME_W-1:0] time_t;

  typedef struct packed {
    time_t lat;
    time_t brk;
  } lp_row_t;

  // Window test: residency pays off and both transitions fit.
  function automatic logic state_fits(time_t dur, time_t brk, time_t lat);
    logic [TIME_W:0] round_trip;
    round_trip = {lat, 1'b0};
    return (dur != '0) && (brk <= dur) && (round_trip <= {1'b0, dur});
  endfunction

  function automatic time_t wake_point(time_t idle_end, time_t lat);
    return idle_end - lat;
  endfunction

  // Wrap-safe "now is at or after target".
  function automatic logic time_reached(time_t now, time_t target);
    time_t diff;
    diff = now - target;
    return ~diff[TIME_W-1];
  endfunction
endpackage

// File: rtl/lp_cfg_table.sv
module lp_cfg_table #(
  parameter int NUM_ST = 4,
  localparam int IW = $clog2(NUM_ST)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [IW-1:0]  cfg_sel,
  input  logic           cfg_fld,
  input  lp_pkg::time_t  cfg_wdata,
  output lp_pkg::lp_row_t rows [1:NUM_ST-1]
);
  lp_pkg::lp_row_t tbl_q [1:NUM_ST-1];

  generate
    for (genvar k = 1; k < NUM_ST; k++) begin : g_row
      logic row_hit;
      assign row_hit = cfg_we && (cfg_sel == IW'(k));
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          tbl_q[k] <= '0;
        end else if (row_hit) begin
          if (cfg_fld) tbl_q[k].brk <= cfg_wdata;
          else         tbl_q[k].lat <= cfg_wdata;
        end
      end
      assign rows[k] = tbl_q[k];
    end
  endgenerate
endmodule

// File: rtl/lp_select.sv
module lp_select #(
  parameter int NUM_ST = 4,
  localparam int IW = $clog2(NUM_ST)
) (
  input  lp_pkg::lp_row_t rows [1:NUM_ST-1],
  input  lp_pkg::time_t   idle_dur,
  output logic [IW-1:0]   pick,
  output lp_pkg::time_t   pick_lat
);
  logic [NUM_ST-1:1] elig;

  generate
    for (genvar k = 1; k < NUM_ST; k++) begin : g_elig
      assign elig[k] = lp_pkg::state_fits(idle_dur, rows[k].brk, rows[k].lat);
    end
  endgenerate

  // Ascending scan: the last (deepest) eligible state wins.
  always_comb begin
    pick     = '0;
    pick_lat = '0;
    for (int k = 1; k < NUM_ST; k++) begin
      if (elig[k]) begin
        pick     = IW'(k);
        pick_lat = rows[k].lat;
      end
    end
  end
endmodule

// File: rtl/lp_wake_timer.sv
module lp_wake_timer #(
  parameter int NUM_ST = 4,
  localparam int IW = $clog2(NUM_ST)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept_evt,
  input  logic [IW-1:0] pick,
  input  lp_pkg::time_t pick_lat,
  input  lp_pkg::time_t idle_end,
  input  lp_pkg::time_t now,
  input  logic          early_wake,
  output logic [IW-1:0] state_idx,
  output logic          sleep_req,
  output logic          wake_req,
  output logic          timer_hit
);
  logic          sleep_q, wake_q;
  logic [IW-1:0] idx_q;
  lp_pkg::time_t wake_at_q;
  logic          exit_evt;

  assign timer_hit = sleep_q && lp_pkg::time_reached(now, wake_at_q);
  assign exit_evt  = sleep_q && (timer_hit || early_wake);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sleep_q   <= 1'b0;
      wake_q    <= 1'b0;
      idx_q     <= '0;
      wake_at_q <= '0;
    end else begin
      wake_q <= 1'b0;
      if (!sleep_q) begin
        if (accept_evt && (pick != '0)) begin
          sleep_q   <= 1'b1;
          idx_q     <= pick;
          wake_at_q <= lp_pkg::wake_point(idle_end, pick_lat);
        end
      end else if (exit_evt) begin
        sleep_q <= 1'b0;
        idx_q   <= '0;
        wake_q  <= 1'b1;
      end
    end
  end

  assign state_idx = idx_q;
  assign sleep_req = sleep_q;
  assign wake_req  = wake_q;

  // R4
  sleep_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |-> (state_idx != '0));
  // R6
  wake_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |=> !wake_req);
  // R7
  early_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req && early_wake) |=> (wake_req && !sleep_req && state_idx == '0));
  // R8
  hold_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req && !timer_hit && !early_wake) |=> (sleep_req && $stable(state_idx)));
  // R9
  no_spurious_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_req |=> !wake_req);
endmodule

// File: rtl/lp_state_picker.sv
module lp_state_picker #(
  parameter int NUM_ST = 4,
  localparam int IW = $clog2(NUM_ST),
  localparam int TW = lp_pkg::TIME_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_sel,
  input  logic          cfg_fld,
  input  logic [TW-1:0] cfg_wdata,
  input  logic          idle_vld,
  input  logic [TW-1:0] idle_dur,
  input  logic [TW-1:0] idle_end,
  input  logic [TW-1:0] now,
  input  logic          early_wake,
  output logic [IW-1:0] state_idx,
  output logic          sleep_req,
  output logic          wake_req
);
  lp_pkg::lp_row_t rows [1:NUM_ST-1];
  logic [IW-1:0]   pick;
  lp_pkg::time_t   pick_lat;
  logic            accept_evt;
  logic            timer_hit;

  assign accept_evt = idle_vld && !sleep_req;

  lp_cfg_table #(.NUM_ST(NUM_ST)) u_table (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_fld(cfg_fld), .cfg_wdata(cfg_wdata), .rows(rows)
  );

  lp_select #(.NUM_ST(NUM_ST)) u_select (
    .rows(rows), .idle_dur(idle_dur), .pick(pick), .pick_lat(pick_lat)
  );

  lp_wake_timer #(.NUM_ST(NUM_ST)) u_timer (
    .clk(clk), .rst_n(rst_n), .accept_evt(accept_evt), .pick(pick),
    .pick_lat(pick_lat), .idle_end(idle_end), .now(now),
    .early_wake(early_wake), .state_idx(state_idx), .sleep_req(sleep_req),
    .wake_req(wake_req), .timer_hit(timer_hit)
  );

  // R4
  entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_evt && pick != '0) |=> (sleep_req && state_idx == $past(pick)));
  // R5
  zero_dur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_evt && idle_dur == '0) |=> (!sleep_req && state_idx == '0));
  // R6
  timer_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timer_hit |=> (wake_req && !sleep_req));
endmodule

// File: tb/lp_state_picker_tb.sv
`timescale 1ns/1ps
module lp_state_picker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic        cfg_fld = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        idle_vld = 1'b0;
  logic [31:0] idle_dur = '0;
  logic [31:0] idle_end = '0;
  logic [31:0] now = 32'd100;
  logic        early_wake = 1'b0;
  logic [1:0]  state_idx;
  logic        sleep_req;
  logic        wake_req;

  int vec_n = 0;
  int bad_n = 0;
  longint lat_m [1:3];
  longint brk_m [1:3];

  always #2 clk = ~clk;
  always @(negedge clk) now <= now + 32'd1;

  lp_state_picker u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_fld(cfg_fld), .cfg_wdata(cfg_wdata), .idle_vld(idle_vld),
    .idle_dur(idle_dur), .idle_end(idle_end), .now(now),
    .early_wake(early_wake), .state_idx(state_idx), .sleep_req(sleep_req),
    .wake_req(wake_req)
  );

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic chk(string req, longint act, longint exp);
    vec_n++;
    if (act != exp) begin
      bad_n++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic wr(int sel, int fld, longint val);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_fld = 1'(fld); cfg_wdata = 32'(val);
    step();
    cfg_we = 1'b0;
    if (sel != 0) begin
      if (fld == 0) lat_m[sel] = val; else brk_m[sel] = val;
    end
  endtask

  function automatic int expect_pick(longint d);
    int r = 0;
    for (int k = 1; k <= 3; k++)
      if (d > 0 && brk_m[k] <= d && lat_m[k] + lat_m[k] <= d) r = k;
    return r;
  endfunction

  // Apply one prediction; mode 0 = early wake, 1 = timer wake.
  task automatic apply(longint d, int mode);
    int exp_i;
    longint w;
    int seen;
    exp_i = expect_pick(d);
    idle_vld = 1'b1; idle_dur = 32'(d); idle_end = now + 32'(d);
    w = longint'(idle_end) - (exp_i != 0 ? lat_m[exp_i] : 0);
    step();
    idle_vld = 1'b0;
    chk("R3/R4 state_idx", state_idx, exp_i);
    chk("R4/R5 sleep_req", sleep_req, exp_i != 0);
    if (exp_i == 0) begin
      step();
      chk("R5 no wake_req", wake_req, 0);
    end else if (mode == 0) begin
      early_wake = 1'b1; step(); early_wake = 1'b0;
      chk("R7 wake_req", wake_req, 1);
      chk("R7 sleep_req low", sleep_req, 0);
      chk("R7 state_idx 0", state_idx, 0);
      step();
      chk("R7 pulse ends", wake_req, 0);
    end else begin
      seen = 0;
      for (int c = 0; c < 200 && !seen; c++) begin
        step();
        if (wake_req) begin
          seen = 1;
          chk("R6 wake cycle", longint'(now) - 1, w);
          chk("R6 state_idx 0", state_idx, 0);
        end
      end
      chk("R6 wake seen", seen, 1);
      step();
      chk("R6 pulse ends", wake_req, 0);
    end
  endtask

  initial begin
    for (int k = 1; k <= 3; k++) begin lat_m[k] = 0; brk_m[k] = 0; end
    step(); step();
    chk("R1 state_idx", state_idx, 0);
    chk("R1 sleep_req", sleep_req, 0);
    chk("R1 wake_req", wake_req, 0);
    rst_n = 1'b1;
    step();

    // Table A: break-even dominates.
    wr(1, 0, 2);  wr(1, 1, 4);
    wr(2, 0, 5);  wr(2, 1, 12);
    wr(3, 0, 10); wr(3, 1, 30);
    wr(0, 0, 0);  wr(0, 1, 0);   // R2: row 0 ignored
    for (int d = 0; d <= 70; d++) apply(d, d % 2);

    // R9: early wake while active.
    early_wake = 1'b1; step(); early_wake = 1'b0; step();
    chk("R9 no wake_req", wake_req, 0);
    chk("R9 state_idx", state_idx, 0);

    // R8: new prediction while asleep is ignored.
    idle_vld = 1'b1; idle_dur = 32'd40; idle_end = now + 32'd40;
    step();
    idle_vld = 1'b0;
    chk("R8 entry", state_idx, 3);
    idle_vld = 1'b1; idle_dur = 32'd5; idle_end = now + 32'd5;
    step();
    idle_vld = 1'b0;
    chk("R8 ignored", state_idx, 3);
    step();
    chk("R8 still", state_idx, 3);
    early_wake = 1'b1; step(); early_wake = 1'b0;
    chk("R7 wake after R8", wake_req, 1);
    step();

    // R10: wake point already in the past.
    idle_vld = 1'b1; idle_dur = 32'd40; idle_end = now - 32'd3;
    step();
    idle_vld = 1'b0;
    chk("R10 entry", state_idx, 3);
    step();
    chk("R10 immediate wake", wake_req, 1);
    step();

    // Table B: latency bars state 2, larger breaks too.
    wr(1, 0, 3);  wr(1, 1, 1);
    wr(2, 0, 20); wr(2, 1, 10);
    wr(3, 0, 8);  wr(3, 1, 12);
    wr(0, 0, 1);  wr(0, 1, 1);   // R2: row 0 ignored
    for (int d = 0; d <= 70; d++) apply(d, (d + 1) % 2);
    apply(64'h8000_0000, 0);
    apply(64'hFFFF_FFFF, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad_n++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
    $finish;
  end
endmodule